// File: doc/BRIEF.md
# Read-Sequence Nonvolatile Command Detector

This block watches the access stream of an 8K x 8 byte-wide memory and spots a hidden command: six consecutive read accesses to a fixed chain of addresses. When the chain completes, it emits a one-clock request to save the memory contents to the nonvolatile copy, or to restore them from it. The last address of the chain alone selects which of the two requests is raised.

Each access is marked by the assertion of the active-low chip enable. That input arrives asynchronously to the block clock. It is passed through a synchroniser and an edge detector, so each assertion counts exactly once, however long chip enable stays low. The address and write-enable level are sampled in the cycle the edge is seen. They must therefore be held stable while chip enable is low. A write, or a read to any address that is not the expected next link, breaks the chain. While the busy input is high, every access is ignored and the progress reached so far is frozen.

The detector is a six-state machine. `S_IDLE` means no progress. `S_P1` to `S_P5` mean that one to five links have been matched. The transitions are:
- `advance`: the expected next address is read.
- `restart`: an address 0x0000 is read out of turn, and the machine moves to `S_P1`.
- `abort`: any other access, and the machine moves to `S_IDLE`.
- `fire_save` and `fire_restore`: `S_P5` goes to `S_IDLE` and pulses the matching request.
- `hold`: busy is high, or there is no access edge, and the state is unchanged.

Top module: `nv_seq_unlock`

## Requirements
- R1: Reads to 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, followed by a read to 0x0F0F produce exactly one `save_req_o` pulse and no `restore_req_o` pulse.
- R2: The same five reads followed by a read to 0x0F0E produce exactly one `restore_req_o` pulse and no `save_req_o` pulse.
- R3: An access with `wr_n_i` low (a write) at any point of the chain returns progress to zero. This holds even when the write is to 0x0000 or to the expected next address. A chain with such a write yields no request.
- R4: A read to an address other than the expected next link returns progress to zero. If that read is to 0x0000, it counts as the first link of a new chain.
- R5: One assertion of `cs_n_i` (high to low) counts as one access, whatever its length. Address and `wr_n_i` are sampled once per assertion.
- R6: While `busy_i` is high, accesses are ignored, the progress is held, and neither request output is high.
- R7: Each request is one clock long, and the two requests are never high together.
- R8: Asserting `rst_n` (active low, asynchronous) clears all progress and drives both requests low.
- R9: After a request, progress is zero. Repeating only the sixth address yields no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip enable of the memory, asynchronous; each falling edge is one access |
| wr_n_i | input | 1 | Active-low write enable level; high marks a read |
| addr_i | input | 13 | Memory address, stable while `cs_n_i` is low |
| busy_i | input | 1 | High while a nonvolatile copy runs; freezes detection |
| save_req_o | output | 1 | One-clock request to save to nonvolatile storage |
| restore_req_o | output | 1 | One-clock request to restore from nonvolatile storage |

## Verification
The hardest situation to reach from the ports is a long chain that breaks late in a specific way. Examples are a write to the very address expected next, a stray 0x0000 that must restart rather than abort, and busy rising between link five and link six. Uniform random addresses almost never get past the first link. The random stimulus is therefore weighted: most accesses present the link that the bench's own progress model expects next, and the rest inject writes, magic addresses out of order, arbitrary addresses and busy windows. Directed sequences then pin down each corner exactly, including a long chip-enable hold and a reset at `S_P5`.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;

    localparam int ADDR_W = 13;

    // Magic chain, one constant per link
    localparam logic [ADDR_W-1:0] LINK0        = 13'h0000;
    localparam logic [ADDR_W-1:0] LINK1        = 13'h1555;
    localparam logic [ADDR_W-1:0] LINK2        = 13'h0AAA;
    localparam logic [ADDR_W-1:0] LINK3        = 13'h1FFF;
    localparam logic [ADDR_W-1:0] LINK4        = 13'h10F0;
    localparam logic [ADDR_W-1:0] LINK_SAVE    = 13'h0F0F;
    localparam logic [ADDR_W-1:0] LINK_RESTORE = 13'h0F0E;

    // Classification of one sampled access
    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_K0,
        HIT_K1,
        HIT_K2,
        HIT_K3,
        HIT_K4,
        HIT_SAVE,
        HIT_RESTORE
    } hit_e;

    // Progress through the chain
    typedef enum logic [2:0] {
        S_IDLE,
        S_P1,
        S_P2,
        S_P3,
        S_P4,
        S_P5
    } step_e;

endpackage

// File: rtl/nvseq_strobe_sync.sv
module nvseq_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_async,
    output logic access_stb
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= cs_n_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= chain_q[STAGES-1];
    end

    // High for one cycle on each high-to-low transition of chip enable
    assign access_stb = last_q & ~chain_q[STAGES-1];

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_stb |=> !access_stb);

endmodule

// File: rtl/nvseq_addr_match.sv
module nvseq_addr_match
    import nvseq_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_n,
    output hit_e          hit
);

    always_comb begin
        hit = HIT_NONE;
        if (wr_n) begin
            if      (addr == LINK0)        hit = HIT_K0;
            else if (addr == LINK1)        hit = HIT_K1;
            else if (addr == LINK2)        hit = HIT_K2;
            else if (addr == LINK3)        hit = HIT_K3;
            else if (addr == LINK4)        hit = HIT_K4;
            else if (addr == LINK_SAVE)    hit = HIT_SAVE;
            else if (addr == LINK_RESTORE) hit = HIT_RESTORE;
        end
    end

endmodule

// File: rtl/nvseq_fsm.sv
module nvseq_fsm
    import nvseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic access_stb,
    input  hit_e hit,
    input  logic busy,
    output logic save_req,
    output logic restore_req
);

    step_e state, nxt;
    logic  save_q, restore_q;
    logic  take;

    assign take = access_stb & ~busy;

    function automatic step_e restart_or_abort(hit_e h);
        return (h == HIT_K0) ? S_P1 : S_IDLE;
    endfunction

    always_comb begin
        nxt = state;
        if (take) begin
            unique case (state)
                S_IDLE: nxt = restart_or_abort(hit);
                S_P1:   nxt = (hit == HIT_K1) ? S_P2 : restart_or_abort(hit);
                S_P2:   nxt = (hit == HIT_K2) ? S_P3 : restart_or_abort(hit);
                S_P3:   nxt = (hit == HIT_K3) ? S_P4 : restart_or_abort(hit);
                S_P4:   nxt = (hit == HIT_K4) ? S_P5 : restart_or_abort(hit);
                S_P5: begin
                    if (hit == HIT_SAVE || hit == HIT_RESTORE) nxt = S_IDLE;
                    else                                       nxt = restart_or_abort(hit);
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            save_q    <= 1'b0;
            restore_q <= 1'b0;
        end else begin
            save_q    <= take && (state == S_P5) && (hit == HIT_SAVE);
            restore_q <= take && (state == S_P5) && (hit == HIT_RESTORE);
        end
    end

    assign save_req    = save_q & ~busy;
    assign restore_req = restore_q & ~busy;

    // R7
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, restore_req}));

    // R7
    save_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_q |=> !save_q);

    // R1
    save_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(save_q) |-> $past(state) == S_P5);

    // R9
    idle_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_q || restore_q) |-> state == S_IDLE);

    // R6
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> state == $past(state));

endmodule

// File: rtl/nv_seq_unlock.sv
module nv_seq_unlock
    import nvseq_pkg::*;
#(
    parameter int AW          = ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n_i,
    input  logic          wr_n_i,
    input  logic [AW-1:0] addr_i,
    input  logic          busy_i,
    output logic          save_req_o,
    output logic          restore_req_o
);

    logic access_stb;
    hit_e hit;

    nvseq_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_async (cs_n_i),
        .access_stb (access_stb)
    );

    nvseq_addr_match #(.AW(AW)) u_match (
        .addr (addr_i),
        .wr_n (wr_n_i),
        .hit  (hit)
    );

    nvseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .access_stb  (access_stb),
        .hit         (hit),
        .busy        (busy_i),
        .save_req    (save_req_o),
        .restore_req (restore_req_o)
    );

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !(save_req_o || restore_req_o));

endmodule

// File: tb/nv_seq_unlock_tb.sv
module nv_seq_unlock_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [12:0] addr = '0;
    logic        busy = 1'b0;
    logic        save_req, restore_req;

    int errors = 0;
    int checks = 0;
    int prog = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nv_seq_unlock dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_n_i        (cs_n),
        .wr_n_i        (wr_n),
        .addr_i        (addr),
        .busy_i        (busy),
        .save_req_o    (save_req),
        .restore_req_o (restore_req)
    );

    function automatic logic [12:0] key(int i);
        case (i)
            0: return 13'h0000;
            1: return 13'h1555;
            2: return 13'h0AAA;
            3: return 13'h1FFF;
            default: return 13'h10F0;
        endcase
    endfunction

    // Reference progress model: returns 0 none, 1 save, 2 restore
    function automatic int model_step(logic [12:0] a, logic w_n, logic b);
        int res = 0;
        if (b) return 0;
        if (w_n && prog == 5 && (a == 13'h0F0F || a == 13'h0F0E)) begin
            res  = (a == 13'h0F0F) ? 1 : 2;
            prog = 0;
        end else if (w_n && prog < 5 && a == key(prog)) begin
            prog = prog + 1;
        end else if (w_n && a == 13'h0000) begin
            prog = 1;
        end else begin
            prog = 0;
        end
        return res;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(logic [12:0] a, logic w_n, int hold, string tag);
        int ns = 0;
        int nr = 0;
        int exp;
        @(negedge clk);
        addr = a;
        wr_n = w_n;
        cs_n = 1'b0;
        for (int i = 0; i < hold + 6; i++) begin
            if (i == hold) cs_n = 1'b1;
            @(negedge clk);
            ns += int'(save_req);
            nr += int'(restore_req);
            if (busy && (save_req || restore_req))
                check(0, "R6 request during busy", 1, 0);
        end
        wr_n = 1'b1;
        exp = model_step(a, w_n, busy);
        check(ns == (exp == 1 ? 1 : 0), {tag, " save pulses"}, ns, exp == 1 ? 1 : 0);
        check(nr == (exp == 2 ? 1 : 0), {tag, " restore pulses"}, nr, exp == 2 ? 1 : 0);
    endtask

    task automatic prefix(string tag);
        for (int i = 0; i < 5; i++) access(key(i), 1'b1, 2, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8 reset state
        check(save_req == 0 && restore_req == 0, "R8 outputs in reset", int'(save_req | restore_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(save_req == 0 && restore_req == 0, "R8 outputs after reset", int'(save_req | restore_req), 0);

        // R1 full save chain
        prefix("R1 prefix");
        access(13'h0F0F, 1'b1, 2, "R1 save");
        // R9 lone sixth address again
        access(13'h0F0F, 1'b1, 2, "R9 repeat sixth");
        // R2 full restore chain
        prefix("R2 prefix");
        access(13'h0F0E, 1'b1, 2, "R2 restore");
        // R3 write to the expected link breaks the chain
        access(key(0), 1'b1, 2, "R3");
        access(key(1), 1'b1, 2, "R3");
        access(key(2), 1'b0, 2, "R3 write");
        access(key(3), 1'b1, 2, "R3");
        access(key(4), 1'b1, 2, "R3");
        access(13'h0F0F, 1'b1, 2, "R3 no save");
        // R3 write to 0000 does not restart
        access(key(0), 1'b1, 2, "R3");
        access(key(0), 1'b0, 2, "R3 write0");
        access(key(1), 1'b1, 2, "R3");
        // R4 stray 0000 restarts the chain
        prefix("R4");
        access(key(0), 1'b1, 2, "R4 restart");
        for (int i = 1; i < 5; i++) access(key(i), 1'b1, 2, "R4");
        access(13'h0F0E, 1'b1, 2, "R4 restore after restart");
        // R4 other mismatch aborts
        access(key(0), 1'b1, 2, "R4");
        access(13'h0123, 1'b1, 2, "R4 mismatch");
        access(key(1), 1'b1, 2, "R4 after abort");
        // R5 long chip-enable hold counts once
        access(key(0), 1'b1, 2, "R5");
        access(key(1), 1'b1, 25, "R5 long hold");
        for (int i = 2; i < 5; i++) access(key(i), 1'b1, 1, "R5");
        access(13'h0F0F, 1'b1, 12, "R5 save");
        // R6 busy freezes progress
        prefix("R6");
        busy = 1'b1;
        access(13'h0F0F, 1'b1, 2, "R6 ignored");
        access(13'h0777, 1'b1, 2, "R6 ignored");
        busy = 1'b0;
        access(13'h0F0E, 1'b1, 2, "R6 restore after busy");
        // R8 reset mid-chain
        prefix("R8");
        @(negedge clk);
        rst_n = 1'b0;
        prog = 0;
        @(negedge clk);
        rst_n = 1'b1;
        access(13'h0F0F, 1'b1, 2, "R8 no save after reset");

        // Weighted random stream (R7 via pulse counts)
        for (int n = 0; n < 600; n++) begin
            int m = $urandom % 12;
            logic [12:0] a;
            logic w = 1'b1;
            if (m < 7) a = (prog == 5) ? (($urandom % 2) ? 13'h0F0F : 13'h0F0E) : key(prog);
            else if (m == 7) a = 13'h0000;
            else if (m == 8) a = key($urandom % 5);
            else if (m == 9) begin a = key(prog < 5 ? prog : 0); w = 1'b0; end
            else a = 13'($urandom);
            busy = (($urandom % 15) == 0);
            access(a, w, 1 + ($urandom % 4), "R7 random");
            busy = 1'b0;
        end
        finish_run();
    end

endmodule